// File: doc/BRIEF.md
# Clock-Unit Reset Release Sequencer

This block orders the way reset is lifted inside a clock-generation unit running on the fast clock. It takes a PLL reset and a logic reset, a PLL lock input and a reference-edge pulse that marks a rising reference-clock edge in the fast domain. Once the resets are released in order and the unit is in functional mode, it waits for a reference edge. It then emits an alignment pulse, lifts an aligned internal reset, starts two divided I/O clock enables at fixed offsets, emits a divider-release strobe, and finally raises a stable flag. The system reset unit uses this flag to release the rest of the chip.

Every internal reset is asserted asynchronously and released synchronously through a multi-stage synchronizer. A loss of PLL lock, or a move out of functional mode, drops the sequence back to waiting for the next reference edge. A small configuration register sits beside the sequencer. Its clock-programming field survives a warm reset; the rest of the register does not.

Top module: `clkgen_rst_seq`

## Requirements
- R1: While the PLL reset is low, every sequencer output (align_pulse, aligned_rst_n, div_release, io2x_en, io_en, clocks_stable) and cfg_q are 0.
- R2: The logic reset counts as released only once the PLL reset is also high. A reference edge seen while the PLL reset is low has no effect, even if the logic reset is already high.
- R3: While test_mode or div_bypass is high, reference edges are ignored. Raising either one during a sequence returns all outputs to 0 at the next edge.
- R4: align_pulse is high for exactly one cycle, ALIGN_DLY (3) cycles after the edge that samples an accepted ref_edge.
- R5: aligned_rst_n rises 1 cycle after align_pulse and stays high while the sequence runs.
- R6: io2x_en first pulses 2 cycles after aligned_rst_n rises, then every IO2X_DIV (2) cycles.
- R7: io_en first pulses 4 cycles after aligned_rst_n rises, then every IO_DIV (4) cycles; each io_en pulse coincides with an io2x_en pulse.
- R8: div_release pulses once, for one cycle, DIV_DLY (2) cycles after align_pulse.
- R9: clocks_stable rises 1 cycle after the first io_en pulse and stays high while the sequence runs.
- R10: If pll_locked is low at an edge while a sequence runs, all sequencer outputs are 0 after that edge. A later accepted ref_edge restarts the full sequence.
- R11: A ref_edge that arrives while a sequence runs does not restart or disturb it.
- R12: cfg_q[KEEP_W-1:0] (bits 3:0) keep their value through a warm reset, while the upper bits (7:4) clear to 0. A PLL (cold) reset clears all bits.
- R13: While pll_locked is low and no sequence runs, ref_edge is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock |
| pll_rst_n | input | 1 | PLL/cold reset, active low, released first |
| logic_rst_n | input | 1 | Logic reset, active low, released after pll_rst_n |
| warm_rst_n | input | 1 | Warm reset, active low |
| pll_locked | input | 1 | PLL lock indication |
| ref_edge | input | 1 | One-cycle pulse marking a rising reference-clock edge |
| test_mode | input | 1 | Test mode; must be low for functional operation |
| div_bypass | input | 1 | Divider bypass; must be low for functional operation |
| cfg_we | input | 1 | Configuration write enable |
| cfg_wdata | input | CFG_W | Configuration write data |
| cfg_q | output | CFG_W | Configuration register contents |
| align_pulse | output | 1 | Alignment pulse |
| aligned_rst_n | output | 1 | Aligned internal reset, active low |
| div_release | output | 1 | Divider-release strobe |
| io2x_en | output | 1 | 2x I/O clock edge enable |
| io_en | output | 1 | 1x I/O clock edge enable |
| clocks_stable | output | 1 | All derived clocks and enables are running |

## Verification
The bench builds the block with its default parameters: a two-stage synchronizer, an alignment delay of 3, a release delay of 1, offsets of 2 and 4 for the two I/O clocks, and divider ratios of 2 and 4. With these values the whole timeline to the stable flag spans ten cycles, so random runs of up to 24 cycles see every stage, the periodic pattern after it, and aborts both before and after the stable flag. The 2-to-4 ratio also makes every 1x edge fall on a 2x edge, which brings the coincidence check on the two enables within reach.

// File: rtl/clkgen_rst_pkg.sv
package clkgen_rst_pkg;

   // Top-level state of the release timeline.
   typedef enum logic {
      ST_WAIT = 1'b0,
      ST_RUN  = 1'b1
   } seq_state_e;

endpackage

// File: rtl/crs_sync.sv
// Reset synchronizer: asserts asynchronously, releases after STAGES edges.
module crs_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic arst_n,
   output logic srst_n
);
   if (STAGES < 2) begin : g_bad_stages
      $error("crs_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) chain <= '0;
      else         chain <= {chain[STAGES-2:0], 1'b1};
   end

   assign srst_n = chain[STAGES-1];
endmodule

// File: rtl/crs_divpulse.sv
// Divided clock edge enable: one pulse every RATIO cycles while go is high,
// the first pulse in the first cycle go is seen.
module crs_divpulse #(
   parameter int RATIO = 2
) (
   input  logic clk,
   input  logic srst_n,
   input  logic go,
   output logic pulse
);
   localparam int PW = (RATIO > 2) ? $clog2(RATIO) : 1;
   localparam logic [PW-1:0] LAST = PW'(RATIO - 1);

   if (RATIO < 2) begin : g_bad_ratio
      $error("crs_divpulse: RATIO must be at least 2");
   end

   logic [PW-1:0] phase;

   always_ff @(posedge clk or negedge srst_n) begin
      if (!srst_n)            phase <= '0;
      else if (!go)           phase <= '0;
      else if (phase == LAST) phase <= '0;
      else                    phase <= phase + PW'(1);
   end

   assign pulse = go && (phase == '0);
endmodule

// File: rtl/crs_timeline.sv
// Release timeline: counts fast cycles from the accepted reference edge and
// decodes each stage from the count.
module crs_timeline
   import clkgen_rst_pkg::*;
#(
   parameter int ALIGN_DLY = 3,
   parameter int REL_DLY   = 1,
   parameter int IO2X_DLY  = 2,
   parameter int IO1X_DLY  = 4,
   parameter int DIV_DLY   = 2
) (
   input  logic clk,
   input  logic srst_n,
   input  logic locked,
   input  logic hold,
   input  logic ref_edge,
   output logic align_pulse,
   output logic aligned_rst_n,
   output logic div_release,
   output logic io2x_go,
   output logic io1x_go,
   output logic clocks_stable
);
   localparam int REL_AT    = ALIGN_DLY + REL_DLY;
   localparam int IO2X_AT   = REL_AT + IO2X_DLY;
   localparam int IO1X_AT   = REL_AT + IO1X_DLY;
   localparam int DIV_AT    = ALIGN_DLY + DIV_DLY;
   localparam int STABLE_AT = IO1X_AT + 1;
   localparam int CW        = $clog2(STABLE_AT + 1);

   localparam logic [CW-1:0] C_ALIGN  = CW'(ALIGN_DLY);
   localparam logic [CW-1:0] C_REL    = CW'(REL_AT);
   localparam logic [CW-1:0] C_IO2X   = CW'(IO2X_AT);
   localparam logic [CW-1:0] C_IO1X   = CW'(IO1X_AT);
   localparam logic [CW-1:0] C_DIV    = CW'(DIV_AT);
   localparam logic [CW-1:0] C_STABLE = CW'(STABLE_AT);

   if (ALIGN_DLY < 1 || REL_DLY < 1) begin : g_bad_align
      $error("crs_timeline: ALIGN_DLY and REL_DLY must be at least 1");
   end
   if (IO2X_DLY < 1 || IO1X_DLY < IO2X_DLY) begin : g_bad_io
      $error("crs_timeline: need 1 <= IO2X_DLY <= IO1X_DLY");
   end
   if (DIV_AT > STABLE_AT) begin : g_bad_div
      $error("crs_timeline: divider release must precede stable");
   end

   seq_state_e     state;
   logic [CW-1:0]  cnt;
   logic           running;

   always_ff @(posedge clk or negedge srst_n) begin
      if (!srst_n) begin
         state <= ST_WAIT;
         cnt   <= '0;
      end else begin
         unique case (state)
            ST_WAIT: begin
               cnt <= '0;
               if (ref_edge && locked && !hold) state <= ST_RUN;
            end
            ST_RUN: begin
               if (!locked || hold) begin
                  state <= ST_WAIT;
                  cnt   <= '0;
               end else if (cnt != C_STABLE) begin
                  cnt <= cnt + CW'(1);
               end
            end
            default: state <= ST_WAIT;
         endcase
      end
   end

   assign running       = (state == ST_RUN);
   assign align_pulse   = running && (cnt == C_ALIGN);
   assign aligned_rst_n = running && (cnt >= C_REL);
   assign div_release   = running && (cnt == C_DIV);
   assign io2x_go       = running && (cnt >= C_IO2X);
   assign io1x_go       = running && (cnt >= C_IO1X);
   assign clocks_stable = running && (cnt >= C_STABLE);

   // R4
   align_width_chk: assert property (@(posedge clk) disable iff (!srst_n)
      align_pulse |=> !align_pulse);

   // R5
   release_after_align_chk: assert property (@(posedge clk) disable iff (!srst_n)
      $rose(aligned_rst_n) |-> $past(align_pulse));

   // R10
   lock_loss_chk: assert property (@(posedge clk) disable iff (!srst_n)
      (clocks_stable && !locked) |=> (!clocks_stable && !aligned_rst_n));
endmodule

// File: rtl/crs_cfg_hold.sv
// Configuration register: low KEEP_W bits survive a warm reset.
module crs_cfg_hold #(
   parameter int CFG_W  = 8,
   parameter int KEEP_W = 4
) (
   input  logic             clk,
   input  logic             cold_srst_n,
   input  logic             warm_srst_n,
   input  logic             we,
   input  logic [CFG_W-1:0] wdata,
   output logic [CFG_W-1:0] q
);
   localparam int MISC_W = CFG_W - KEEP_W;

   if (KEEP_W < 1 || KEEP_W >= CFG_W) begin : g_bad_split
      $error("crs_cfg_hold: need 1 <= KEEP_W < CFG_W");
   end

   logic [KEEP_W-1:0] keep_q;
   logic [MISC_W-1:0] misc_q;

   always_ff @(posedge clk or negedge cold_srst_n) begin
      if (!cold_srst_n)            keep_q <= '0;
      else if (we && warm_srst_n)  keep_q <= wdata[KEEP_W-1:0];
   end

   always_ff @(posedge clk or negedge warm_srst_n) begin
      if (!warm_srst_n) misc_q <= '0;
      else if (we)      misc_q <= wdata[CFG_W-1:KEEP_W];
   end

   assign q = {misc_q, keep_q};

   // R12
   keep_through_warm_chk: assert property (@(posedge clk) disable iff (!cold_srst_n)
      !warm_srst_n |=> $stable(keep_q));
endmodule

// File: rtl/clkgen_rst_seq.sv
module clkgen_rst_seq #(
   parameter int SYNC_STAGES = 2,
   parameter int ALIGN_DLY   = 3,
   parameter int REL_DLY     = 1,
   parameter int IO2X_DLY    = 2,
   parameter int IO1X_DLY    = 4,
   parameter int DIV_DLY     = 2,
   parameter int IO2X_DIV    = 2,
   parameter int IO_DIV      = 4,
   parameter int CFG_W       = 8,
   parameter int KEEP_W      = 4
) (
   input  logic             clk,
   input  logic             pll_rst_n,
   input  logic             logic_rst_n,
   input  logic             warm_rst_n,
   input  logic             pll_locked,
   input  logic             ref_edge,
   input  logic             test_mode,
   input  logic             div_bypass,
   input  logic             cfg_we,
   input  logic [CFG_W-1:0] cfg_wdata,
   output logic [CFG_W-1:0] cfg_q,
   output logic             align_pulse,
   output logic             aligned_rst_n,
   output logic             div_release,
   output logic             io2x_en,
   output logic             io_en,
   output logic             clocks_stable
);
   localparam bit EDGES_NEST = ((IO1X_DLY - IO2X_DLY) % IO2X_DIV == 0) &&
                               (IO_DIV % IO2X_DIV == 0);

   logic seq_arst_n, warm_arst_n;
   logic seq_srst_n, warm_srst_n, cold_srst_n;
   logic io2x_go, io1x_go;

   // Logic reset counts only once the PLL reset is also released.
   assign seq_arst_n  = pll_rst_n & logic_rst_n;
   assign warm_arst_n = pll_rst_n & warm_rst_n;

   crs_sync #(.STAGES(SYNC_STAGES)) u_sync_seq (
      .clk(clk), .arst_n(seq_arst_n), .srst_n(seq_srst_n));
   crs_sync #(.STAGES(SYNC_STAGES)) u_sync_cold (
      .clk(clk), .arst_n(pll_rst_n), .srst_n(cold_srst_n));
   crs_sync #(.STAGES(SYNC_STAGES)) u_sync_warm (
      .clk(clk), .arst_n(warm_arst_n), .srst_n(warm_srst_n));

   crs_timeline #(
      .ALIGN_DLY(ALIGN_DLY), .REL_DLY(REL_DLY), .IO2X_DLY(IO2X_DLY),
      .IO1X_DLY(IO1X_DLY), .DIV_DLY(DIV_DLY)
   ) u_timeline (
      .clk           (clk),
      .srst_n        (seq_srst_n),
      .locked        (pll_locked),
      .hold          (test_mode | div_bypass),
      .ref_edge      (ref_edge),
      .align_pulse   (align_pulse),
      .aligned_rst_n (aligned_rst_n),
      .div_release   (div_release),
      .io2x_go       (io2x_go),
      .io1x_go       (io1x_go),
      .clocks_stable (clocks_stable)
   );

   crs_divpulse #(.RATIO(IO2X_DIV)) u_div_io2x (
      .clk(clk), .srst_n(seq_srst_n), .go(io2x_go), .pulse(io2x_en));
   crs_divpulse #(.RATIO(IO_DIV)) u_div_io (
      .clk(clk), .srst_n(seq_srst_n), .go(io1x_go), .pulse(io_en));

   crs_cfg_hold #(.CFG_W(CFG_W), .KEEP_W(KEEP_W)) u_cfg (
      .clk(clk), .cold_srst_n(cold_srst_n), .warm_srst_n(warm_srst_n),
      .we(cfg_we), .wdata(cfg_wdata), .q(cfg_q));

   // R9
   stable_after_io_chk: assert property (@(posedge clk) disable iff (!seq_srst_n)
      $rose(clocks_stable) |-> $past(io_en));

   // R1
   reset_quiet_chk: assert property (@(posedge clk)
      !seq_srst_n |-> (!aligned_rst_n && !clocks_stable && !io_en && !io2x_en));

   if (EDGES_NEST) begin : g_nest_chk
      // R7
      io_on_io2x_chk: assert property (@(posedge clk) disable iff (!seq_srst_n)
         io_en |-> io2x_en);
   end
endmodule

// File: tb/clkgen_rst_seq_test.sv
`timescale 1ns/1ps
module clkgen_rst_seq_test;
   // Timeline offsets taken from the requirements.
   localparam int K_ALIGN  = 3;
   localparam int K_REL    = 4;
   localparam int K_DIV    = 5;
   localparam int K_IO2X   = 6;
   localparam int K_IO     = 8;
   localparam int K_STABLE = 9;

   logic       clk = 1'b0;
   logic       pll_rst_n = 1'b0, logic_rst_n = 1'b0, warm_rst_n = 1'b0;
   logic       pll_locked = 1'b0, ref_edge = 1'b0;
   logic       test_mode = 1'b0, div_bypass = 1'b0;
   logic       cfg_we = 1'b0;
   logic [7:0] cfg_wdata = '0;
   logic [7:0] cfg_q;
   logic       align_pulse, aligned_rst_n, div_release, io2x_en, io_en, clocks_stable;

   int total = 0;
   int fails = 0;

   always #2 clk = ~clk;

   clkgen_rst_seq uut (
      .clk(clk), .pll_rst_n(pll_rst_n), .logic_rst_n(logic_rst_n),
      .warm_rst_n(warm_rst_n), .pll_locked(pll_locked), .ref_edge(ref_edge),
      .test_mode(test_mode), .div_bypass(div_bypass), .cfg_we(cfg_we),
      .cfg_wdata(cfg_wdata), .cfg_q(cfg_q), .align_pulse(align_pulse),
      .aligned_rst_n(aligned_rst_n), .div_release(div_release),
      .io2x_en(io2x_en), .io_en(io_en), .clocks_stable(clocks_stable));

   function automatic logic e_align(int k);  return k == K_ALIGN;  endfunction
   function automatic logic e_rel(int k);    return k >= K_REL;    endfunction
   function automatic logic e_div(int k);    return k == K_DIV;    endfunction
   function automatic logic e_io2x(int k);   return (k >= K_IO2X) && ((k - K_IO2X) % 2 == 0); endfunction
   function automatic logic e_io(int k);     return (k >= K_IO) && ((k - K_IO) % 4 == 0); endfunction
   function automatic logic e_stable(int k); return k >= K_STABLE; endfunction

   task automatic chk(string req, string what, logic [7:0] act, logic [7:0] exp);
      total++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic chk_quiet(string req);
      chk(req, "align_pulse",   align_pulse,   1'b0);
      chk(req, "aligned_rst_n", aligned_rst_n, 1'b0);
      chk(req, "div_release",   div_release,   1'b0);
      chk(req, "io2x_en",       io2x_en,       1'b0);
      chk(req, "io_en",         io_en,         1'b0);
      chk(req, "clocks_stable", clocks_stable, 1'b0);
   endtask

   task automatic chk_step(int k, string ctx);
      chk({"R4 ", ctx}, "align_pulse",   align_pulse,   e_align(k));
      chk({"R5 ", ctx}, "aligned_rst_n", aligned_rst_n, e_rel(k));
      chk({"R8 ", ctx}, "div_release",   div_release,   e_div(k));
      chk({"R6 ", ctx}, "io2x_en",       io2x_en,       e_io2x(k));
      chk({"R7 ", ctx}, "io_en",         io_en,         e_io(k));
      chk({"R9 ", ctx}, "clocks_stable", clocks_stable, e_stable(k));
   endtask

   // Pulse ref_edge; returns at the negedge after the sampling edge (k = 0).
   task automatic pulse_ref();
      ref_edge = 1'b1;
      @(negedge clk);
      ref_edge = 1'b0;
   endtask

   // One sequence of len cycles, optional stray ref pulse, then an abort.
   task automatic run_seq(int len, int abort_kind, bit stray);
      int stray_at;
      string ctx;
      stray_at = stray ? $urandom_range(0, len - 1) : -1;
      ctx = stray ? "R11" : "run";
      pulse_ref();
      for (int k = 0; k < len; k++) begin
         if (k > 0) @(negedge clk);
         chk_step(k, ctx);
         ref_edge = (k == stray_at);
      end
      ref_edge = 1'b0;
      case (abort_kind)
         0:       pll_locked = 1'b0;
         1:       test_mode  = 1'b1;
         default: div_bypass = 1'b1;
      endcase
      @(negedge clk);
      chk_quiet(abort_kind == 0 ? "R10" : "R3");
      pll_locked = 1'b1;
      test_mode  = 1'b0;
      div_bypass = 1'b0;
      @(negedge clk);
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      fails++;
      total++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end

   initial begin : main
      logic [7:0] v;
      void'($urandom(32'd20240611));

      // R1 reset state
      repeat (3) @(negedge clk);
      chk_quiet("R1");
      chk("R1", "cfg_q", cfg_q, 8'h00);

      // R2 logic reset released while PLL reset still low
      logic_rst_n = 1'b1;
      warm_rst_n  = 1'b1;
      pll_locked  = 1'b1;
      repeat (3) @(negedge clk);
      pulse_ref();
      repeat (12) @(negedge clk);
      chk_quiet("R2");

      pll_rst_n = 1'b1;
      repeat (4) @(negedge clk);

      // Directed full sequence
      run_seq(16, 0, 1'b0);

      // R13 ref ignored without lock
      pll_locked = 1'b0;
      @(negedge clk);
      pulse_ref();
      repeat (10) @(negedge clk);
      chk_quiet("R13");
      pll_locked = 1'b1;
      @(negedge clk);

      // R3 ref ignored in test mode / divider bypass
      test_mode = 1'b1;
      pulse_ref();
      repeat (10) @(negedge clk);
      chk_quiet("R3");
      test_mode  = 1'b0;
      div_bypass = 1'b1;
      pulse_ref();
      repeat (10) @(negedge clk);
      chk_quiet("R3");
      div_bypass = 1'b0;
      @(negedge clk);

      // Abort right after the stable flag rises
      run_seq(K_STABLE + 1, 0, 1'b0);
      // Abort before the aligned reset is lifted
      run_seq(2, 1, 1'b0);

      // Random runs
      for (int i = 0; i < 24; i++) begin
         int gap;
         gap = $urandom_range(0, 5);
         for (int g = 0; g < gap; g++) begin
            @(negedge clk);
            chk_quiet("R10");
         end
         run_seq($urandom_range(1, 24), $urandom_range(0, 2), 1'($urandom_range(0, 1)));
      end

      // R12 warm reset keeps the low field
      for (int i = 0; i < 4; i++) begin
         v = 8'($urandom_range(0, 255));
         cfg_wdata = v;
         cfg_we = 1'b1;
         @(negedge clk);
         cfg_we = 1'b0;
         @(negedge clk);
         chk("R12", "cfg_q write", cfg_q, v);
         warm_rst_n = 1'b0;
         @(negedge clk);
         warm_rst_n = 1'b1;
         repeat (3) @(negedge clk);
         chk("R12", "cfg_q after warm", cfg_q, {4'h0, v[3:0]});
      end

      // Cold reset clears everything
      cfg_wdata = 8'hC3;
      cfg_we = 1'b1;
      @(negedge clk);
      cfg_we = 1'b0;
      pll_rst_n = 1'b0;
      @(negedge clk);
      chk("R12", "cfg_q after cold", cfg_q, 8'h00);
      chk_quiet("R1");
      pll_rst_n = 1'b1;
      repeat (4) @(negedge clk);

      // Restart after cold reset
      run_seq(12, 0, 1'b0);

      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end
endmodule